// File: doc/BRIEF.md
# Field Memory Power-Up Initialization Sequencer

This controller puts a two-port field-delay memory into a known state after power-up. The memory has a write port and a read port. Each port has its own clock enable and its own address-pointer reset. After the supply is reported good, the sequencer waits a settling interval. It then runs a burst of dummy clock cycles on both ports at the same time and closes each burst with a single pointer reset. When both ports have finished, it raises `ready`. Downstream logic may begin normal traffic only while `ready` is high.

When the supply was still settling when the sequence was accepted, a longer sequence is used. Each port first gets a reset, then its dummy burst, then a second reset. The settling interval, the length of each port's dummy burst and the quiet gap after every reset are parameters. A `restart` pulse abandons whatever is in progress, drops `ready`, and returns the controller to idle.

All outputs are plain control levels that are valid for one clock cycle each. None of them has a handshake.

Top module: `fm_init_seq`

## Requirements
- R1: While `rst_n` is low, and in the idle state, `wr_clk_en`, `wr_rst`, `rd_clk_en`, `rd_rst` and `ready` are all low.
- R2: The sequence is accepted at the first clock edge in idle at which `supply_ok` is high. For the next STAB_CYCLES cycles every output stays low.
- R3: Normal sequence. In the cycle right after the settling interval, each port starts a run of consecutive clock-enable cycles. The run is DUMMY_WR cycles on the write port and DUMMY_RD cycles on the read port. It is followed directly by a one-cycle reset on that port.
- R4: Both ports start their sequences in the same cycle and run independently, so ports with different burst lengths finish at different times.
- R5: Long sequence. If `supply_unstable` is high at the edge that accepts the sequence, each port gets a one-cycle reset, then its burst of dummy cycles, then a second one-cycle reset.
- R6: Every reset pulse lasts exactly one cycle and is followed by at least GAP_CYCLES cycles with that port's reset low. The port is complete only after that gap.
- R7: `ready` rises one cycle after the later of the two ports completes. It stays high until `restart` is asserted.
- R8: `restart` sampled high at a clock edge returns the controller to idle. From the next cycle, all outputs are low until a new sequence is accepted.
- R9: Outside idle, `supply_ok` and `supply_unstable` have no effect on the outputs. The sequence type is fixed when the sequence is accepted.
- R10: On a given port, the clock enable and the reset are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | Supply reported valid; sampled only in idle |
| supply_unstable | input | 1 | Selects the long sequence; sampled with `supply_ok` |
| restart | input | 1 | Abandon the current sequence and return to idle |
| wr_clk_en | output | 1 | Write-port dummy clock enable |
| wr_rst | output | 1 | Write-port pointer reset pulse |
| rd_clk_en | output | 1 | Read-port dummy clock enable |
| rd_rst | output | 1 | Read-port pointer reset pulse |
| ready | output | 1 | Both ports initialized |

## Verification
The bench drives four patterns and compares every output against a reference model on every cycle:

- **Plain start.** The supply is accepted with the unstable flag low, and the two ports use unequal burst lengths. This separates the short sequence from the long one and shows that `ready` waits for the slower port.
- **Long start.** The same comparison with the unstable flag high. It exposes a missing leading reset or a misplaced trailing reset.
- **Restart points.** A restart is issued in the middle of a dummy burst, during the settling wait and after `ready`. This shows that nothing is left over from the abandoned sequence.
- **Ignored inputs.** `supply_unstable` and `supply_ok` are toggled while a sequence runs. Any effect on the outputs shows that these inputs were wrongly sampled outside idle.

// File: rtl/fmi_pkg.sv
package fmi_pkg;
  typedef enum logic [1:0] {
    T_IDLE,
    T_WAIT,
    T_RUN,
    T_DONE
  } top_state_t;

  typedef enum logic [2:0] {
    P_IDLE,
    P_PRE_RST,
    P_DUMMY,
    P_RST,
    P_GAP,
    P_DONE
  } port_state_t;
endpackage

// File: rtl/fmi_stab_timer.sv
module fmi_stab_timer #(
  parameter int STAB_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES + 1) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == CW'(STAB_CYCLES - 1));
endmodule

// File: rtl/fmi_port_seq.sv
module fmi_port_seq
  import fmi_pkg::*;
#(
  parameter int DUMMY = 80,
  parameter int GAP   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic start,
  input  logic long_mode,
  output logic clk_en,
  output logic rst_pulse,
  output logic done
);
  localparam int MAXC = (DUMMY > GAP) ? DUMMY : GAP;
  localparam int CW   = $clog2(MAXC + 1);

  port_state_t   st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      st  <= P_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        P_IDLE: if (start) begin
          st  <= long_mode ? P_PRE_RST : P_DUMMY;
          cnt <= '0;
        end
        P_PRE_RST: begin
          st  <= P_DUMMY;
          cnt <= '0;
        end
        P_DUMMY: begin
          if (cnt == CW'(DUMMY - 1)) st <= P_RST;
          cnt <= cnt + 1'b1;
        end
        P_RST: begin
          st  <= P_GAP;
          cnt <= '0;
        end
        P_GAP: begin
          if (cnt == CW'(GAP - 1)) st <= P_DONE;
          cnt <= cnt + 1'b1;
        end
        default: st <= st;
      endcase
    end
  end

  assign clk_en    = (st == P_DUMMY);
  assign rst_pulse = (st == P_PRE_RST) || (st == P_RST);
  assign done      = (st == P_DONE);
endmodule

// File: rtl/fm_init_seq.sv
module fm_init_seq
  import fmi_pkg::*;
#(
  parameter int STAB_CYCLES = 100,
  parameter int DUMMY_WR    = 80,
  parameter int DUMMY_RD    = 80,
  parameter int GAP_CYCLES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic supply_unstable,
  input  logic restart,
  output logic wr_clk_en,
  output logic wr_rst,
  output logic rd_clk_en,
  output logic rd_rst,
  output logic ready
);
  localparam int NPORT = 2;

  top_state_t       state;
  logic             long_q;
  logic             stab_done;
  logic [NPORT-1:0] p_en, p_rst, p_done;

  fmi_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == T_WAIT), .expired(stab_done)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    localparam int D = (g == 0) ? DUMMY_WR : DUMMY_RD;
    fmi_port_seq #(.DUMMY(D), .GAP(GAP_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .clear(restart), .start(stab_done),
      .long_mode(long_q), .clk_en(p_en[g]), .rst_pulse(p_rst[g]),
      .done(p_done[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      state  <= T_IDLE;
      long_q <= 1'b0;
    end else begin
      case (state)
        T_IDLE: if (supply_ok) begin
          state  <= T_WAIT;
          long_q <= supply_unstable;
        end
        T_WAIT: if (stab_done) state <= T_RUN;
        T_RUN:  if (&p_done)   state <= T_DONE;
        default: state <= state;
      endcase
    end
  end

  assign wr_clk_en = p_en[0];
  assign wr_rst    = p_rst[0];
  assign rd_clk_en = p_en[1];
  assign rd_rst    = p_rst[1];
  assign ready     = (state == T_DONE);
endmodule

// File: rtl/fmi_checker.sv
module fmi_checker (
  input logic clk,
  input logic rst_n,
  input logic restart,
  input logic wr_clk_en,
  input logic wr_rst,
  input logic rd_clk_en,
  input logic rd_rst,
  input logic ready
);
  AST_WR_EN_RST_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(wr_clk_en && wr_rst)); // R10
  AST_RD_EN_RST_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rd_clk_en && rd_rst)); // R10
  AST_WR_RST_GAP: assert property (@(posedge clk) disable iff (!rst_n || restart) wr_rst |=> !wr_rst ##1 !wr_rst); // R6
  AST_RD_RST_GAP: assert property (@(posedge clk) disable iff (!rst_n || restart) rd_rst |=> !rd_rst ##1 !rd_rst); // R6
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ready |-> !(wr_clk_en || wr_rst || rd_clk_en || rd_rst)); // R7
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (ready && !restart) |=> ready); // R7
  AST_RESTART_IDLE: assert property (@(posedge clk) disable iff (!rst_n) restart |=> !(ready || wr_clk_en || wr_rst || rd_clk_en || rd_rst)); // R8
endmodule

bind fm_init_seq fmi_checker u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart),
  .wr_clk_en(wr_clk_en), .wr_rst(wr_rst),
  .rd_clk_en(rd_clk_en), .rd_rst(rd_rst), .ready(ready)
);

// File: tb/fm_init_seq_test.sv
module fm_init_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int STAB = 20;
  localparam int DW   = 80;
  localparam int DR   = 84;
  localparam int GAP  = 2;

  logic clk = 0, rst_n = 0, supply_ok = 0, supply_unstable = 0, restart = 0;
  logic wr_clk_en, wr_rst, rd_clk_en, rd_rst, ready;
  int   checks = 0, failures = 0;
  bit   finished = 0;
  string tag = "R1";

  // reference model state
  bit     m_active = 0;
  bit     m_long   = 0;
  integer m_n      = 0;

  fm_init_seq #(.STAB_CYCLES(STAB), .DUMMY_WR(DW), .DUMMY_RD(DR), .GAP_CYCLES(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .supply_unstable(supply_unstable),
    .restart(restart), .wr_clk_en(wr_clk_en), .wr_rst(wr_rst),
    .rd_clk_en(rd_clk_en), .rd_rst(rd_rst), .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n || restart) begin
      m_active <= 0; m_n <= 0;
    end else if (!m_active) begin
      if (supply_ok) begin m_active <= 1; m_n <= 0; m_long <= supply_unstable; end
    end else m_n <= m_n + 1;
  end

  function automatic void port_exp(input int d, input int k, input bit lng,
                                   output bit en, output bit rs, output int dn);
    if (lng) begin
      en = (k >= 1) && (k <= d); rs = (k == 0) || (k == d + 1); dn = d + 2 + GAP;
    end else begin
      en = (k >= 0) && (k < d);  rs = (k == d);                 dn = d + 1 + GAP;
    end
  endfunction

  task automatic check1(input string t, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", t, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit ew, erw, er, err, erdy;
    int dw, dr, k;
    ew = 0; erw = 0; er = 0; err = 0; erdy = 0;
    if (m_active && m_n >= STAB) begin
      k = m_n - STAB;
      port_exp(DW, k, m_long, ew, erw, dw);
      port_exp(DR, k, m_long, er, err, dr);
      erdy = (k >= ((dw > dr) ? dw : dr) + 1);
    end
    checks++;
    if ({wr_clk_en, wr_rst, rd_clk_en, rd_rst, ready} !== {ew, erw, er, err, erdy}) begin
      failures++;
      $display("FAIL %s outputs actual=%b expected=%b t=%0t", tag,
               {wr_clk_en, wr_rst, rd_clk_en, rd_rst, ready}, {ew, erw, er, err, erdy}, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    tag = "R1";
    supply_ok = 1;
    step(3);
    check1("R1", ready, 1'b0, "ready in reset");
    @(negedge clk); rst_n = 0; supply_ok = 0;
    @(negedge clk); rst_n = 1;
    step(5);
    check1("R1", wr_clk_en | rd_clk_en | wr_rst | rd_rst, 1'b0, "idle outputs");

    // R2/R3/R4: plain start with unequal bursts; R9: flags toggled mid-run
    tag = "R3";
    supply_ok = 1; supply_unstable = 0;
    step(1);
    tag = "R2"; step(STAB);
    tag = "R4";
    supply_ok = 0; supply_unstable = 1;
    step(30);
    tag = "R9"; supply_ok = 1; supply_unstable = 0; step(10);
    supply_unstable = 1; step(10);
    tag = "R6"; step(DR - 45 + GAP + 5);
    tag = "R7"; step(5);
    check1("R7", ready, 1'b1, "ready after plain sequence");
    check1("R7", m_long, 1'b0, "model chose plain sequence");

    // R8: restart after ready
    tag = "R8";
    supply_ok = 0;
    restart = 1; step(1); restart = 0;
    step(1);
    check1("R8", ready, 1'b0, "ready after restart");
    step(4);

    // R5: long start, restart mid-burst, then full long run
    tag = "R5";
    supply_ok = 1; supply_unstable = 1;
    step(1); supply_ok = 0;
    step(STAB + 40);
    tag = "R8"; restart = 1; step(1); restart = 0;
    step(1);
    check1("R8", wr_clk_en | rd_clk_en, 1'b0, "burst stopped by restart");
    tag = "R5";
    supply_ok = 1; step(1); supply_ok = 0; supply_unstable = 0;
    step(STAB + DR + GAP + 8);
    check1("R5", ready, 1'b1, "ready after long sequence");
    check1("R5", m_long, 1'b1, "model chose long sequence");

    // R8: restart during the settling wait, then stay idle
    tag = "R8";
    restart = 1; step(1); restart = 0;
    supply_ok = 1; step(5); supply_ok = 0;
    restart = 1; step(1); restart = 0;
    step(STAB + 10);
    check1("R8", wr_clk_en | wr_rst | rd_clk_en | rd_rst | ready, 1'b0, "idle after wait restart");

    // R10: spot check exclusivity on a fresh plain run
    tag = "R10";
    supply_ok = 1; step(1); supply_ok = 0;
    step(STAB + DW);
    check1("R10", wr_clk_en & wr_rst, 1'b0, "write enable and reset overlap");
    check1("R10", rd_clk_en & rd_rst, 1'b0, "read enable and reset overlap");
    step(20);
    finish_run();
  end
endmodule